// File: doc/BRIEF.md
# Configurable Port Bus-Width Matcher

This block adapts a memory that stores 36-bit words to an external data port whose width can be switched at run time. The port can be 36, 18 or 9 bits wide. It moves one full word per access. On a write it gathers several narrow beats from the pins into a staging register and then issues one memory write. On a read it captures one full word and presents it on the pins as a sequence of narrow beats, driving an output-enable for each 9-bit lane.

Three select inputs choose the port format: a bus-match enable, a narrow-size select and a byte-order select. These selects are captured when an access is accepted. A sub-counter then steps through the slices of the word, one per clock. The memory array, address generation and arbitration sit outside the block. The memory read data is sampled as a plain input, and the block presents a write strobe with the assembled word.

Top module: `bus_width_matcher`

## Requirements
- R1: An access is accepted by `start` while `busy` is low, and `busy` is then high for exactly the beat count, starting in the next cycle. The beat count is 1 when `match_en`=0 (full 36-bit path), 2 when `match_en`=1 and `narrow_sel`=0 (half mode), and 4 when `match_en`=1 and `narrow_sel`=1 (quarter mode).
- R2: In half mode each beat is 18 bits on pin bits 17..0. On read beats `lane_oe` equals 4'b0011. On writes, `pin_in` bits 35..18 are ignored.
- R3: In quarter mode each beat is 9 bits on pin bits 8..0. On read beats `lane_oe` equals 4'b0001 and `pin_out` bits 35..9 are zero. On writes, `pin_in` bits 35..9 are ignored.
- R4: With `big_end`=0, beat k carries slice k of the word, where slice 0 holds the lowest bits. The least significant slice comes first, for both reads and writes.
- R5: With `big_end`=1, beat k carries slice (beats-1-k). The most significant slice comes first, for both reads and writes.
- R6: On a write, `pin_in` is captured at the clock edge that ends each busy cycle. `mem_we` is high for exactly one cycle, the cycle after the last beat, and `mem_wdata` then holds the assembled word.
- R7: On a read, the word on `mem_rdata` is sampled at the edge that accepts the access. Later changes of `mem_rdata` do not affect the beats.
- R8: `match_en`, `narrow_sel` and `big_end` are captured when an access is accepted. Changes to them during an access have no effect on it.
- R9: `start` is ignored while `busy` is high. Holding it high neither restarts nor lengthens the running access.
- R10: While `rst` is high, and after it falls until the first access, `busy`, `mem_we`, `lane_oe` and `pin_out` are all zero.
- R11: `lane_oe` and `pin_out` are zero in every cycle that is not a read beat, including write beats. Read beats in full mode drive `lane_oe` = 4'b1111.
- R12: The sub-counter is zero in the first beat of each access and advances by one on each following beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new access (taken only when idle) |
| wr_req | input | 1 | 1 = write access, 0 = read access, sampled with start |
| match_en | input | 1 | 0 = full-width port, 1 = narrow port |
| narrow_sel | input | 1 | With match_en=1: 0 = 18-bit beats, 1 = 9-bit beats |
| big_end | input | 1 | 0 = least significant slice first, 1 = most significant first |
| pin_in | input | 36 | Port data from the pins for writes |
| mem_rdata | input | 36 | Word read from memory |
| pin_out | output | 36 | Port data toward the pins for reads |
| lane_oe | output | 4 | Output enable per 9-bit lane of the pins |
| busy | output | 1 | An access is in progress (one cycle per beat) |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_wdata | output | 36 | Assembled word for the memory write |

## Verification
The checker assumes that `rst` is asserted from the first clock. It also assumes that the bound counter and the captured selects change only through the sequencer, so two accesses are always separated by at least one idle cycle. The bench drives all inputs on the falling edge. It issues `start` only when a sequence has ended, except in the deliberate held-start case. Even then the release happens in the idle cycle, so every access seen by the checker begins from a clean idle state. The selects and `mem_rdata` are disturbed only while `busy` is high, which is where the design claims to ignore them.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_HALF    = 2'd1,
        MODE_QUARTER = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  big;
    } cfg_t;

    function automatic mode_e decode_mode(input logic match, input logic narrow);
        if (!match) begin
            return MODE_FULL;
        end
        return narrow ? MODE_QUARTER : MODE_HALF;
    endfunction

    function automatic int beats_of(input mode_e m);
        case (m)
            MODE_HALF:    return 2;
            MODE_QUARTER: return 4;
            default:      return 1;
        endcase
    endfunction

    function automatic int lanes_per_beat(input mode_e m, input int lanes);
        return lanes / beats_of(m);
    endfunction

    function automatic int slice_of(input cfg_t c, input int cnt);
        return c.big ? (beats_of(c.mode) - 1 - cnt) : cnt;
    endfunction

endpackage

// File: rtl/bwm_seq.sv
module bwm_seq
    import bwm_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             wr_in,
    input  cfg_t             cfg_in,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output cfg_t             cfg,
    output logic             wr,
    output logic             accept,
    output logic             commit
);

    logic last;

    assign accept = start && !busy;
    assign last   = (int'(cnt) == beats_of(cfg.mode) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cfg    <= '{mode: MODE_FULL, big: 1'b0};
            wr     <= 1'b0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
                cfg  <= cfg_in;
                wr   <= wr_in;
            end else if (busy) begin
                if (last) begin
                    busy   <= 1'b0;
                    cnt    <= '0;
                    commit <= wr;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bwm_rd_scatter.sv
module bwm_rd_scatter
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int CNT_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           accept,
    input  logic [LANES-1:0][LANE_W-1:0]   word_in,
    input  logic                           busy,
    input  logic                           wr,
    input  cfg_t                           cfg,
    input  logic [CNT_W-1:0]               cnt,
    output logic [LANES-1:0][LANE_W-1:0]   lanes_out,
    output logic [LANES-1:0]               oe
);

    localparam int LIDX_W = $clog2(LANES);

    logic [LANES-1:0][LANE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (accept) begin
            hold_q <= word_in;
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic              oe_l;
        logic [LANE_W-1:0] d_l;
        always_comb begin
            int lpb;
            int src;
            lpb  = lanes_per_beat(cfg.mode, LANES);
            src  = slice_of(cfg, int'(cnt)) * lpb + j;
            oe_l = busy && !wr && (j < lpb);
            d_l  = oe_l ? hold_q[LIDX_W'(src)] : '0;
        end
        assign oe[j]        = oe_l;
        assign lanes_out[j] = d_l;
    end

endmodule

// File: rtl/bwm_wr_gather.sv
module bwm_wr_gather
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int CNT_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [LANES-1:0][LANE_W-1:0]   lanes_in,
    input  logic                           busy,
    input  logic                           wr,
    input  cfg_t                           cfg,
    input  logic [CNT_W-1:0]               cnt,
    output logic [LANES-1:0][LANE_W-1:0]   stage
);

    localparam int LIDX_W = $clog2(LANES);

    for (genvar w = 0; w < LANES; w++) begin : g_word_lane
        logic              hit;
        logic [LANE_W-1:0] src_d;
        always_comb begin
            int lpb;
            lpb   = lanes_per_beat(cfg.mode, LANES);
            hit   = busy && wr && ((w / lpb) == slice_of(cfg, int'(cnt)));
            src_d = lanes_in[LIDX_W'(w % lpb)];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[w] <= '0;
            end else if (hit) begin
                stage[w] <= src_d;
            end
        end
    end

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    wr_req,
    input  logic                    match_en,
    input  logic                    narrow_sel,
    input  logic                    big_end,
    input  logic [LANE_W*LANES-1:0] pin_in,
    input  logic [LANE_W*LANES-1:0] mem_rdata,
    output logic [LANE_W*LANES-1:0] pin_out,
    output logic [LANES-1:0]        lane_oe,
    output logic                    busy,
    output logic                    mem_we,
    output logic [LANE_W*LANES-1:0] mem_wdata
);

    localparam int MAX_BEATS = 4;
    localparam int CNT_W     = $clog2(MAX_BEATS);

    cfg_t             cfg_req;
    cfg_t             seq_cfg;
    logic [CNT_W-1:0] seq_cnt;
    logic             seq_wr;
    logic             accept;

    logic [LANES-1:0][LANE_W-1:0] rd_word;
    logic [LANES-1:0][LANE_W-1:0] rd_lanes;
    logic [LANES-1:0][LANE_W-1:0] wr_lanes;
    logic [LANES-1:0][LANE_W-1:0] stage;

    assign cfg_req.mode = decode_mode(match_en, narrow_sel);
    assign cfg_req.big  = big_end;

    assign rd_word   = mem_rdata;
    assign wr_lanes  = pin_in;
    assign pin_out   = rd_lanes;
    assign mem_wdata = stage;

    bwm_seq #(.CNT_W(CNT_W)) seq_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .wr_in  (wr_req),
        .cfg_in (cfg_req),
        .busy   (busy),
        .cnt    (seq_cnt),
        .cfg    (seq_cfg),
        .wr     (seq_wr),
        .accept (accept),
        .commit (mem_we)
    );

    bwm_rd_scatter #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) rd_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .word_in   (rd_word),
        .busy      (busy),
        .wr        (seq_wr),
        .cfg       (seq_cfg),
        .cnt       (seq_cnt),
        .lanes_out (rd_lanes),
        .oe        (lane_oe)
    );

    bwm_wr_gather #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) wr_i (
        .clk      (clk),
        .rst      (rst),
        .lanes_in (wr_lanes),
        .busy     (busy),
        .wr       (seq_wr),
        .cfg      (seq_cfg),
        .cnt      (seq_cnt),
        .stage    (stage)
    );

endmodule

// File: rtl/bwm_chk.sv
module bwm_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       mode,
    input logic             big,
    input logic             wr,
    input logic [LANES-1:0] lane_oe,
    input logic             mem_we
);

    localparam logic [LANES-1:0] M_FULL    = '1;
    localparam logic [LANES-1:0] M_HALF    = LANES'((1 << (LANES/2)) - 1);
    localparam logic [LANES-1:0] M_QUARTER = LANES'((1 << (LANES/4)) - 1);

    // R11
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy || wr) |-> (lane_oe == '0));

    // R3
    oe_quarter_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr && mode == 2'd2) |-> (lane_oe == M_QUARTER));

    // R2
    oe_half_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr && mode == 2'd1) |-> (lane_oe == M_HALF));

    // R11
    oe_full_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr && mode == 2'd0) |-> (lane_oe == M_FULL));

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R6
    we_after_seq_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (!busy && $past(busy) && $past(wr)));

    // R12
    cnt_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt == '0));

    // R12
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cnt == $past(cnt) + 1'b1));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mode) && $stable(big) && $stable(wr)));

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mode == 2'd0) |-> (cnt == '0));

endmodule

bind bus_width_matcher bwm_chk #(.LANES(LANES), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cnt     (seq_cnt),
    .mode    (seq_cfg.mode),
    .big     (seq_cfg.big),
    .wr      (seq_wr),
    .lane_oe (lane_oe),
    .mem_we  (mem_we)
);

// File: tb/bus_width_matcher_tb_top.sv
module bus_width_matcher_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 36;
    localparam int WATCHDOG   = 100000;

    // {wr, match, narrow, big} in the top hex digit, word below
    localparam logic [39:0] VEC [0:11] = '{
        40'h0123456789, 40'h1FEDCBA987, 40'h4A5A53C3CF, 40'h50F0F1E1E2,
        40'h68C7B6A594, 40'h71F3E5D7C9, 40'h813579BDF1, 40'h9C0DE12345,
        40'hC2468ACE02, 40'hDC0FFEE123, 40'hE9ABCDEF01, 40'hF7E1D2C3B4
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         wr_req = 1'b0;
    logic         match_en = 1'b0;
    logic         narrow_sel = 1'b0;
    logic         big_end = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] mem_rdata = '0;
    logic [W-1:0] pin_out;
    logic [3:0]   lane_oe;
    logic         busy;
    logic         mem_we;
    logic [W-1:0] mem_wdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_width_matcher dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .wr_req     (wr_req),
        .match_en   (match_en),
        .narrow_sel (narrow_sel),
        .big_end    (big_end),
        .pin_in     (pin_in),
        .mem_rdata  (mem_rdata),
        .pin_out    (pin_out),
        .lane_oe    (lane_oe),
        .busy       (busy),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbeats(input bit m, input bit n);
        return !m ? 1 : (n ? 4 : 2);
    endfunction

    function automatic logic [W-1:0] slice_mask(input bit m, input bit n);
        logic [W:0] one;
        one = 1;
        return W'((one << (W / nbeats(m, n))) - 1);
    endfunction

    function automatic logic [W-1:0] exp_slice(input logic [W-1:0] word, input bit m,
                                               input bit n, input bit b, input int k);
        int nb;
        int idx;
        nb  = nbeats(m, n);
        idx = b ? (nb - 1 - k) : k;
        return (word >> (idx * (W / nb))) & slice_mask(m, n);
    endfunction

    function automatic logic [3:0] exp_oe(input bit m, input bit n);
        return !m ? 4'hF : (n ? 4'h1 : 4'h3);
    endfunction

    function automatic string order_tag(input bit m, input bit n, input bit b);
        if (!m) return "R1";
        if (n)  return b ? "R5/R3" : "R4/R3";
        return b ? "R5/R2" : "R4/R2";
    endfunction

    // One complete access. flip: disturb selects mid-access (R8).
    // hold: keep start high during the access (R9). mem_rdata is always
    // disturbed after acceptance (R7).
    task automatic access(input bit wr, input bit m, input bit n, input bit b,
                          input logic [W-1:0] word, input bit flip, input bit hold,
                          input string tag);
        int nb;
        nb = nbeats(m, n);
        @(negedge clk);
        wr_req     = wr;
        match_en   = m;
        narrow_sel = n;
        big_end    = b;
        mem_rdata  = word;
        start      = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        mem_rdata = ~word;
        if (flip) begin
            match_en   = ~m;
            narrow_sel = ~n;
            big_end    = ~b;
        end
        for (int k = 0; k < nb; k++) begin
            check(busy == 1'b1, {tag, " R1 busy"}, W'(busy), W'(1));
            if (wr) begin
                check(lane_oe == 4'h0 && pin_out == '0, {tag, " R11 write beat"},
                      W'(pin_out), '0);
                pin_in = (36'h5A5A5A5A5 & ~slice_mask(m, n)) | exp_slice(word, m, n, b, k);
            end else begin
                check(pin_out == exp_slice(word, m, n, b, k),
                      {tag, " ", order_tag(m, n, b), " R7 read beat"},
                      pin_out, exp_slice(word, m, n, b, k));
                check(lane_oe == exp_oe(m, n), {tag, " R11 lane_oe"},
                      W'(lane_oe), W'(exp_oe(m, n)));
            end
            check(mem_we == 1'b0, {tag, " R6 early strobe"}, W'(mem_we), '0);
            @(negedge clk);
        end
        check(busy == 1'b0, {tag, " R1 R9 length"}, W'(busy), '0);
        check(lane_oe == 4'h0 && pin_out == '0, {tag, " R11 idle"}, W'(pin_out), '0);
        if (wr) begin
            check(mem_we == 1'b1, {tag, " R6 strobe"}, W'(mem_we), W'(1));
            check(mem_wdata == word, {tag, " ", order_tag(m, n, b), " R6 word"},
                  mem_wdata, word);
        end else begin
            check(mem_we == 1'b0, {tag, " R6 no strobe on read"}, W'(mem_we), '0);
        end
        start = 1'b0;
        match_en   = m;
        narrow_sel = n;
        big_end    = b;
        @(negedge clk);
        check(mem_we == 1'b0, {tag, " R6 single pulse"}, W'(mem_we), '0);
        check(busy == 1'b0, {tag, " R9 no restart"}, W'(busy), '0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && mem_we == 1'b0, "R10 in reset", W'({busy, mem_we}), '0);
        check(lane_oe == 4'h0 && pin_out == '0, "R10 pins in reset", pin_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && mem_we == 1'b0 && lane_oe == 4'h0, "R10 after reset",
              W'({busy, mem_we, lane_oe}), '0);

        for (int i = 0; i < 12; i++) begin
            access(VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:0],
                   1'b0, 1'b0, "vec");
        end

        // R8: selects flipped mid-access, read and write
        access(1'b0, 1'b1, 1'b1, 1'b0, 36'h3C96A5F0E, 1'b1, 1'b0, "R8 rd");
        access(1'b1, 1'b1, 1'b0, 1'b1, 36'h6B2D4E871, 1'b1, 1'b0, "R8 wr");
        // R9: start held high through an access
        access(1'b0, 1'b1, 1'b1, 1'b1, 36'hD1E2F3A4B, 1'b0, 1'b1, "R9 rd");
        access(1'b1, 1'b1, 1'b1, 1'b0, 36'h0A1B2C3D4, 1'b0, 1'b1, "R9 wr");
        // R7: read right after a write with a different memory word
        access(1'b0, 1'b0, 1'b0, 1'b1, 36'hFFFF00000, 1'b0, 1'b0, "R7 full");
        // R3/R5: all-ones corner in quarter mode
        access(1'b0, 1'b1, 1'b1, 1'b1, 36'hFFFFFFFFF, 1'b0, 1'b0, "R3 ones");
        access(1'b1, 1'b1, 1'b1, 1'b1, 36'h000000000, 1'b0, 1'b0, "R3 zeros");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule